// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds two 64-bit operands as a packed vector of independent integer lanes. A run-time size select cuts the word into eight byte lanes, four 16-bit lanes or two 32-bit lanes. All lanes are summed in the same cycle, and no carry ever passes from one lane into its neighbour. A second select chooses how each lane handles overflow:
- it can keep the low bits, which wraps the result;
- it can clamp the result to the lane's unsigned ceiling;
- it can clamp the result to the lane's signed ceiling or floor.

The datapath is fed through a valid/ready stream. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The sum, together with an 8-bit clamp-flag vector, is held in one output register and is offered with `out_valid` on the next cycle. The output stays presented until the consumer takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives a full-rate stream with single-stage back-pressure. The producer must hold its beat stable while `in_valid` is high and `in_ready` is low.

Top module: `simd_sat_adder`

## Requirements
- R1: With `lane_sel`=0, the operands form eight 8-bit lanes, where lane k is bits [8k+7:8k]. Each lane result depends only on the same lane of both operands, and a carry out of one lane never changes another lane.
- R2: With `lane_sel`=1, the operands form four 16-bit lanes. With `lane_sel`=2 or 3, they form two 32-bit lanes. Both layouts keep lane independence.
- R3: With `op_mode`=1 (unsigned clamp), a lane sum above the lane's all-ones value gives all-ones. For a byte lane, 200+100 gives 255 and 255+255 gives 255.
- R4: With `op_mode`=0 or 3 (wrap), each lane keeps only its low bits, so 200+100 in a byte lane gives 44. All clamp flags read 0 in wrap mode.
- R5: With `op_mode`=2 (signed clamp), each lane is treated as two's complement. Positive overflow gives the lane maximum (0x7F for a byte lane) and negative overflow gives the lane minimum (0x80 for a byte lane).
- R6: `out_sat` bit j is set when the lane that holds byte j was clamped. All byte bits of a wider lane carry the same value.
- R7: A beat accepted at a clock edge appears on `out_data`/`out_sat` with `out_valid` high right after that edge. If `out_ready` is high, `out_valid` then falls at the next edge unless a new beat is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_sat` stay unchanged.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| lane_sel | input | 2 | Lane width: 0 byte, 1 16-bit, 2 or 3 32-bit |
| op_mode | input | 2 | Overflow mode: 0/3 wrap, 1 unsigned clamp, 2 signed clamp |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed lane sums |
| out_sat | output | 8 | Per-byte clamp flags |

## Verification
If the lane boundaries are misplaced, the fault shows as a changed neighbouring lane on the first beat with a carry out of a lane boundary. A wrong clamp decision or a wrong flag mapping shows on the same beat, in `out_data` or `out_sat`, one cycle after acceptance. A fault in the output register's hold logic shows only under back-pressure. It appears as a data change or a dropped `out_valid` while `out_ready` is low, in the first stalled cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_32B = 2'd3
  } lane_sel_e;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_USAT  = 2'd1,
    MODE_SSAT  = 2'd2,
    MODE_WRAPB = 2'd3
  } add_mode_e;
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int W = 8
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  simd_pkg::add_mode_e mode,
  output logic [W-1:0]        y,
  output logic                sat
);
  import simd_pkg::*;

  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   ext;
  logic         carry;
  logic         sovf;
  logic [W-1:0] low;

  always_comb begin
    ext   = {1'b0, a} + {1'b0, b};
    low   = ext[W-1:0];
    carry = ext[W];
    sovf  = (a[W-1] == b[W-1]) && (low[W-1] != a[W-1]);
    y     = low;
    sat   = 1'b0;
    unique case (mode)
      MODE_USAT: if (carry) begin
        y   = UMAX;
        sat = 1'b1;
      end
      MODE_SSAT: if (sovf) begin
        y   = a[W-1] ? SMIN : SMAX;
        sat = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: an unsigned clamped sum never falls below either operand
  always_comb begin
    if (mode == MODE_USAT) begin
      a_r3_usat_floor: assert (y >= a && y >= b);
    end
  end

  // R4: wrap modes never raise a clamp flag
  always_comb begin
    if (mode == MODE_WRAP || mode == MODE_WRAPB) begin
      a_r4_wrap_noflag: assert (!sat);
    end
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]      a,
  input  logic [DATA_W-1:0]      b,
  input  simd_pkg::add_mode_e    mode,
  output logic [DATA_W-1:0]      y,
  output logic [DATA_W/8-1:0]    sat_bytes
);
  localparam int LANES    = DATA_W / LANE_W;
  localparam int BYTES_PL = LANE_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_sat;
    simd_lane_add #(.W(LANE_W)) u_add (
      .a    (a[k*LANE_W +: LANE_W]),
      .b    (b[k*LANE_W +: LANE_W]),
      .mode (mode),
      .y    (y[k*LANE_W +: LANE_W]),
      .sat  (lane_sat)
    );
    assign sat_bytes[k*BYTES_PL +: BYTES_PL] = {BYTES_PL{lane_sat}};
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        op_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W/8-1:0] out_sat
);
  import simd_pkg::*;

  localparam int NBYTES = DATA_W / 8;

  add_mode_e mode_e;
  lane_sel_e size_e;
  assign mode_e = add_mode_e'(op_mode);
  assign size_e = lane_sel_e'(lane_sel);

  logic [DATA_W-1:0] y8, y16, y32;
  logic [NBYTES-1:0] s8, s16, s32;

  simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(8)) u_bank8 (
    .a(in_a), .b(in_b), .mode(mode_e), .y(y8), .sat_bytes(s8));
  simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(16)) u_bank16 (
    .a(in_a), .b(in_b), .mode(mode_e), .y(y16), .sat_bytes(s16));
  simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(32)) u_bank32 (
    .a(in_a), .b(in_b), .mode(mode_e), .y(y32), .sat_bytes(s32));

  logic [DATA_W-1:0] sel_y;
  logic [NBYTES-1:0] sel_s;

  always_comb begin
    unique case (size_e)
      LANE_8:  begin sel_y = y8;  sel_s = s8;  end
      LANE_16: begin sel_y = y16; sel_s = s16; end
      default: begin sel_y = y32; sel_s = s32; end
    endcase
  end

  logic       take;
  logic [1:0] size_q;
  logic [1:0] mode_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= '0;
      size_q    <= '0;
      mode_q    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= sel_y;
      out_sat   <= sel_s;
      size_q    <= lane_sel;
      mode_q    <= op_mode;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: an accepted beat is presented on the next cycle
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8: a stalled result holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));

  // R6: wide lanes report the same flag on every byte they cover
  a_r6_flag_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && size_q != 2'd0) |->
      (out_sat[0] == out_sat[1] && out_sat[2] == out_sat[3] &&
       out_sat[4] == out_sat[5] && out_sat[6] == out_sat[7]));

  // R4: a wrapped result carries no clamp flags
  a_r4_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mode_q == 2'd0 || mode_q == 2'd3)) |-> (out_sat == '0));
endmodule

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [1:0]  lane_sel = '0;
  logic [1:0]  op_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_sat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simd_sat_adder u_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .lane_sel(lane_sel), .op_mode(op_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sat(out_sat));

  function automatic logic [71:0] ref_add(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] sz, input logic [1:0] md);
    logic [63:0] res = '0;
    logic [7:0]  flg = '0;
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint unsigned mask = (64'd1 << w) - 1;
    for (int k = 0; k < 64 / w; k++) begin
      longint unsigned la = (a >> (k * w)) & mask;
      longint unsigned lb = (b >> (k * w)) & mask;
      longint unsigned s  = la + lb;
      longint unsigned r  = s & mask;
      bit c = 1'b0;
      if (md == 2'd1 && s > mask) begin
        r = mask; c = 1'b1;
      end else if (md == 2'd2) begin
        longint sa = (la >> (w - 1)) ? longint'(la) - longint'(mask) - 1 : longint'(la);
        longint sb = (lb >> (w - 1)) ? longint'(lb) - longint'(mask) - 1 : longint'(lb);
        longint ss = sa + sb;
        longint mx = longint'(mask >> 1);
        if (ss > mx) begin r = mask >> 1; c = 1'b1; end
        else if (ss < -mx - 1) begin r = (mask >> 1) + 1; c = 1'b1; end
      end
      res = res | (64'(r) << (k * w));
      for (int j = 0; j < w / 8; j++) flg[k * (w / 8) + j] = c;
    end
    return {flg, res};
  endfunction

  task automatic check(input string req, input bit ok, input logic [71:0] act,
                       input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sz, input logic [1:0] md);
    logic [71:0] e = ref_add(a, b, sz, md);
    in_a = a; in_b = b; lane_sel = sz; op_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid && {out_sat, out_data} == e, {out_sat, out_data}, e);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R9: reset state
    check("R9", !out_valid && in_ready, {70'd0, out_valid, in_ready}, 72'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 / R4: byte corner cases
    run_op("R3", 64'h00000000000000C8, 64'h0000000000000064, 2'd0, 2'd1);
    check("R3", out_data[7:0] == 8'd255, 72'(out_data), 72'd255);
    run_op("R3", 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'd0, 2'd1);
    run_op("R4", 64'h00000000000000C8, 64'h0000000000000064, 2'd0, 2'd0);
    check("R4", out_data == 64'd44, 72'(out_data), 72'd44);
    run_op("R4", 64'hC8C8C8C8C8C8C8C8, 64'h6464646464646464, 2'd1, 2'd3);
    // R1: carry out of byte 0 must not reach byte 1
    run_op("R1", 64'h00000000000000FF, 64'h0000000000000001, 2'd0, 2'd0);
    check("R1", out_data == 64'd0, 72'(out_data), 72'd0);
    // R2: 16-bit and 32-bit lane boundaries
    run_op("R2", 64'h0000FFFF0000FFFF, 64'h0000000100000001, 2'd1, 2'd0);
    run_op("R2", 64'h00000000FFFFFFFF, 64'h0000000000000001, 2'd2, 2'd0);
    check("R2", out_data == 64'd0, 72'(out_data), 72'd0);
    run_op("R2", 64'h7FFFFFFF80000000, 64'h0000000180000000, 2'd3, 2'd2);
    // R5: signed clamp at both ends
    run_op("R5", 64'h7F7F80807F7F8080, 64'h0101FFFF0101FFFF, 2'd0, 2'd2);
    check("R5", out_data == 64'h7F7F80807F7F8080, 72'(out_data), 72'h7F7F80807F7F8080);
    run_op("R5", 64'h7FFF80007FFF8000, 64'h0001800000018000, 2'd1, 2'd2);
    // R6: flag replication in 16-bit lanes
    run_op("R6", 64'hFFFF000000000000, 64'h0001000000000000, 2'd1, 2'd1);
    check("R6", out_sat == 8'hC0, 72'(out_sat), 72'hC0);
    // R7: out_valid falls after drain
    @(negedge clk);
    check("R7", !out_valid, 72'(out_valid), 72'd0);
    // R8: back-pressure hold
    out_ready = 1'b0;
    run_op("R8", 64'h1122334455667788, 64'h1111111111111111, 2'd0, 2'd0);
    in_a = '1; in_b = '1; in_valid = 1'b1;
    @(negedge clk);
    check("R8", out_valid && !in_ready && out_data == 64'h2233445566778899,
          72'(out_data), 72'h2233445566778899);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8", !out_valid, 72'(out_valid), 72'd0);
    // R1 / R2 / R3 / R4 / R5: random mix
    for (int i = 0; i < 400; i++) begin
      run_op("R1_R2_random", {$urandom, $urandom}, {$urandom, $urandom},
             2'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule